// File: doc/BRIEF.md
# Serial ADC Frame Receiver

This block is the host side of a serial link to a 12-bit successive-approximation converter. When the caller signals that a conversion has finished, the block pulls an active-low frame-sync line low and waits a set number of cycles. It then toggles a serial clock whose low and high phases each last a set number of cycles. A data bit is captured in the last system-clock cycle before each falling serial-clock edge. The converter launches each bit on the rising edge before it, and launches the first bit when frame sync falls.

After the twelfth capture, the serial clock stays low, with frame sync still low, for a tail period. Both lines then return high together. In that same cycle the assembled word is presented with a one-cycle valid strobe. A guard period follows, during which no new frame may begin. A start request that arrives while a frame or the guard period is running is dropped, and a sticky overrun flag records it. All of these durations are parameters counted in system-clock cycles.

Top module: `sfr_rx`

## Requirements
- R1: While reset is held, frame sync and serial clock are high, the valid strobe is low and the overrun flag is low. Whenever frame sync is high, the serial clock is high.
- R2: A start request that is high at a clock edge while the block is idle pulls frame sync low from that edge. The first falling serial-clock edge follows exactly SETUP_CYC cycles later.
- R3: One frame has exactly DATA_W falling serial-clock edges, spaced LOW_CYC+HIGH_CYC cycles apart. Each low phase lasts LOW_CYC cycles, so the first rising edge comes LOW_CYC cycles after the first falling edge.
- R4: The data input is sampled at the clock edge that makes the serial clock fall. The first sample is the most significant bit (bit DATA_W-1 of the word) and the last is bit 0.
- R5: After the last falling edge, frame sync and the serial clock both stay low for TAIL_CYC cycles. Both then rise at the same edge.
- R6: The valid strobe is high for exactly one cycle, in the cycle in which frame sync rises. The word output holds that word until the next strobe.
- R7: A start request that arrives while the block is not idle has no effect on the running frame and sets the overrun flag. The flag stays set until the next accepted start clears it.
- R8: For GUARD_CYC cycles after the strobe, start requests are ignored: frame sync stays high and the overrun flag is set.
- R9: A whole frame takes SETUP_CYC + (DATA_W-1)*(LOW_CYC+HIGH_CYC) + TAIL_CYC cycles, counted from the accepting edge to the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_done_i | input | 1 | Conversion finished; requests a frame |
| sdata_i | input | 1 | Serial data from the converter |
| fsync_n_o | output | 1 | Active-low frame sync |
| sclk_o | output | 1 | Serial clock, idles high |
| word_o | output | DATA_W | Last assembled word |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| overrun_o | output | 1 | Sticky flag for a dropped start request |

## Verification
The hardest situations to reach are start requests that land in the few cycles where they must be dropped: halfway through the bit stream, and in the first cycle of the guard window right after the strobe. The bench drives a one-cycle start pulse at a chosen sample index inside a frame. It also drives a pulse in the cycle right after the strobe. It then checks that frame timing and word content are unchanged, that frame sync stays high through the guard period, and that the overrun flag stays set until the next accepted frame clears it.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_LOW   = 3'd2,
      ST_HIGH  = 3'd3,
      ST_TAIL  = 3'd4,
      ST_GUARD = 3'd5
   } sfr_state_e;
endpackage

// File: rtl/sfr_phase_timer.sv
module sfr_phase_timer #(
   parameter int CW = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          done_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cnt_q <= '0;
      else if (load_i)            cnt_q <= load_val_i;
      else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sfr_shift_capture.sv
module sfr_shift_capture #(
   parameter int DATA_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              cap_i,
   input  logic              bit_i,
   output logic [DATA_W-1:0] shreg_o,
   output logic              last_o
);
   localparam int BW = $clog2(DATA_W) + 1;

   logic [BW-1:0]     cnt_q;
   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (cap_i) begin
         cnt_q <= cnt_q + 1'b1;
         sh_q  <= {sh_q[DATA_W-2:0], bit_i};
      end
   end

   assign shreg_o = sh_q;
   assign last_o  = (cnt_q == BW'(DATA_W - 1));

   // R3: never more than DATA_W captures in one frame
   assert_capture_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_i |-> (cnt_q < BW'(DATA_W)));
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
   import sfr_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int SETUP_CYC = 3,
   parameter int LOW_CYC   = 3,
   parameter int HIGH_CYC  = 3,
   parameter int TAIL_CYC  = 2,
   parameter int GUARD_CYC = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              conv_done_i,
   input  logic              sdata_i,
   output logic              fsync_n_o,
   output logic              sclk_o,
   output logic [DATA_W-1:0] word_o,
   output logic              word_valid_o,
   output logic              overrun_o
);
   localparam int M1   = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
   localparam int M2   = (HIGH_CYC > TAIL_CYC) ? HIGH_CYC : TAIL_CYC;
   localparam int M3   = (M1 > M2) ? M1 : M2;
   localparam int MAXC = (M3 > GUARD_CYC) ? M3 : GUARD_CYC;
   localparam int CW   = $clog2(MAXC) + 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sfr_rx: DATA_W must be at least 2");
      end
      if (SETUP_CYC < 1 || LOW_CYC < 1 || HIGH_CYC < 1 ||
          TAIL_CYC < 1 || GUARD_CYC < 1) begin : g_bad_timing
         $error("sfr_rx: every phase needs at least one cycle");
      end
   endgenerate

   sfr_state_e        st_q, st_d;
   logic              t_load, t_done, cap, clr, last;
   logic [CW-1:0]     t_val;
   logic [DATA_W-1:0] shreg;
   logic              fire;
   logic [DATA_W-1:0] word_q;
   logic              valid_q, ovr_q;

   sfr_phase_timer #(.CW(CW)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (t_load),
      .load_val_i (t_val),
      .done_o     (t_done)
   );

   sfr_shift_capture #(.DATA_W(DATA_W)) u_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clr),
      .cap_i   (cap),
      .bit_i   (sdata_i),
      .shreg_o (shreg),
      .last_o  (last)
   );

   always_comb begin
      st_d   = st_q;
      t_load = 1'b0;
      t_val  = '0;
      cap    = 1'b0;
      clr    = 1'b0;
      fire   = 1'b0;
      unique case (st_q)
         ST_IDLE: if (conv_done_i) begin
            st_d = ST_SETUP; t_load = 1'b1; t_val = CW'(SETUP_CYC - 1); clr = 1'b1;
         end
         ST_SETUP: if (t_done) begin
            cap = 1'b1; st_d = ST_LOW; t_load = 1'b1; t_val = CW'(LOW_CYC - 1);
         end
         ST_LOW: if (t_done) begin
            st_d = ST_HIGH; t_load = 1'b1; t_val = CW'(HIGH_CYC - 1);
         end
         ST_HIGH: if (t_done) begin
            cap = 1'b1; t_load = 1'b1;
            if (last) begin st_d = ST_TAIL; t_val = CW'(TAIL_CYC - 1); end
            else      begin st_d = ST_LOW;  t_val = CW'(LOW_CYC - 1);  end
         end
         ST_TAIL: if (t_done) begin
            fire = 1'b1; st_d = ST_GUARD; t_load = 1'b1; t_val = CW'(GUARD_CYC - 1);
         end
         ST_GUARD: if (t_done) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         word_q  <= '0;
         valid_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         st_q    <= st_d;
         valid_q <= fire;
         if (fire) word_q <= shreg;
         if (conv_done_i && st_q != ST_IDLE) ovr_q <= 1'b1;
         else if (conv_done_i)               ovr_q <= 1'b0;
      end
   end

   assign fsync_n_o    = (st_q == ST_IDLE) || (st_q == ST_GUARD);
   assign sclk_o       = !((st_q == ST_LOW) || (st_q == ST_TAIL));
   assign word_o       = word_q;
   assign word_valid_o = valid_q;
   assign overrun_o    = ovr_q;

   // R1: serial clock idles high outside a frame
   assert_sclk_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fsync_n_o |-> sclk_o);
   // R2: accepted start drops frame sync at the next edge
   assert_start_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_done_i && fsync_n_o && st_q == ST_IDLE) |=> !fsync_n_o);
   // R3: falling serial-clock edges only inside a frame
   assert_fall_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sclk_o) |-> !fsync_n_o);
   // R5: frame sync rises only together with the strobe
   assert_fsync_rise_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fsync_n_o) |-> word_valid_o);
   // R6: strobe lasts a single cycle
   assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_valid_o |=> !word_valid_o);
   // R7: a dropped start sets the overrun flag
   assert_overrun_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_done_i && st_q != ST_IDLE) |=> overrun_o);
endmodule

// File: tb/sfr_rx_tb.sv
module sfr_rx_tb_top;
   localparam int W = 12, S = 3, L = 3, H = 3, T = 2, G = 4;
   localparam int FRAME = S + (W - 1) * (L + H) + T;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdata = 1'b0;
   logic fsync_n, sclk, valid, ovr;
   logic [W-1:0] word;
   logic [W-1:0] adc_word = '0;
   int bidx = 0;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   sfr_rx #(.DATA_W(W), .SETUP_CYC(S), .LOW_CYC(L), .HIGH_CYC(H),
            .TAIL_CYC(T), .GUARD_CYC(G)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .conv_done_i(start), .sdata_i(sdata),
      .fsync_n_o(fsync_n), .sclk_o(sclk), .word_o(word),
      .word_valid_o(valid), .overrun_o(ovr));

   // converter model: first bit on frame-sync fall, next bit on each rise
   always @(negedge fsync_n) begin bidx = W - 1; sdata = adc_word[W-1]; end
   always @(posedge sclk) if (!fsync_n && bidx > 0) begin bidx = bidx - 1; sdata = adc_word[bidx]; end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // starts at a negedge; ends at the sample carrying the strobe
   task automatic run_frame(input logic [W-1:0] w, input int inj, input bit exp_ovr);
      int n = 0, falls = 0, rises = 0, first_fall = -1, last_fall = -1;
      int first_rise = -1, rise_fs = -1, vn = -1, bad_gap = 0;
      logic psclk = 1'b1;
      logic [W-1:0] got = '0;
      adc_word = w;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(fsync_n == 1'b0, "R2 fsync low after start", fsync_n, 0);
      chk(ovr == 1'b0, "R7 overrun cleared by accepted start", ovr, 0);
      while (n < 400 && vn < 0) begin
         if (psclk && !sclk) begin
            if (first_fall < 0) first_fall = n;
            else if (n - last_fall != L + H) bad_gap++;
            last_fall = n; falls++;
         end
         if (!psclk && sclk) begin
            if (first_rise < 0) first_rise = n;
            rises++;
         end
         if (fsync_n && rise_fs < 0) rise_fs = n;
         if (valid) begin vn = n; got = word; end
         psclk = sclk;
         if (vn < 0) begin
            start = (n == inj);
            @(negedge clk);
            start = 1'b0;
            n++;
         end
      end
      chk(first_fall == S, "R2 setup before first fall", first_fall, S);
      chk(falls == W, "R3 falling edges per frame", falls, W);
      chk(bad_gap == 0, "R3 fall spacing", bad_gap, 0);
      chk(first_rise == S + L, "R3 first low phase", first_rise, S + L);
      chk(got == w, "R4 assembled word MSB first", got, w);
      chk(rise_fs == last_fall + T, "R5 tail hold", rise_fs, last_fall + T);
      chk(sclk == 1'b1, "R5 sclk rises with fsync", sclk, 1);
      chk(vn == FRAME, "R9 frame length", vn, FRAME);
      chk(ovr == exp_ovr, "R7 overrun flag", ovr, exp_ovr);
   endtask

   task automatic idle_wait();
      repeat (G + 1) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(fsync_n == 1'b1, "R1 reset fsync", fsync_n, 1);
      chk(sclk == 1'b1, "R1 reset sclk", sclk, 1);
      chk(valid == 1'b0, "R1 reset valid", valid, 0);
      chk(ovr == 1'b0, "R1 reset overrun", ovr, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_patterns();
      logic [W-1:0] pats [5] = '{12'hA5C, 12'hFFF, 12'h000, 12'h801, 12'h001};
      foreach (pats[i]) begin
         run_frame(pats[i], -1, 1'b0);
         @(negedge clk);
         chk(valid == 1'b0, "R6 strobe one cycle", valid, 0);
         chk(word == pats[i], "R6 word held", word, pats[i]);
         idle_wait();
      end
   endtask

   task automatic t_midframe();
      run_frame(12'h3C6, 20, 1'b1);
      idle_wait();
      chk(ovr == 1'b1, "R7 overrun sticky", ovr, 1);
      run_frame(12'h5A5, -1, 1'b0);
      idle_wait();
   endtask

   task automatic t_guard();
      int seen_low = 0;
      run_frame(12'h7E1, -1, 1'b0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < G + 2; k++) begin
         if (!fsync_n) seen_low++;
         @(negedge clk);
      end
      chk(seen_low == 0, "R8 guard ignores start", seen_low, 0);
      chk(ovr == 1'b1, "R8 overrun in guard", ovr, 1);
      chk(word == 12'h7E1, "R6 word held in guard", word, 12'h7E1);
      run_frame(12'h19B, -1, 1'b0);
      idle_wait();
   endtask

   initial begin
      t_reset();
      t_patterns();
      t_midframe();
      t_guard();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule